// File: doc/BRIEF.md
# Trap Entry and Delegation Controller

This block decides where a trap goes and what architectural state it leaves behind. When the core raises a trap, it presents the cause, the faulting PC, an optional bad address, the current privilege, the status word, the two delegation masks, the two trap vectors and the debug controls. One clock later the block returns a complete update bundle. The bundle holds the next PC, the next privilege, write enables and data for the supervisor or machine cause, exception-PC and bad-address registers, the new status word, any debug-state write, a load-reservation clear and a translation-flush pulse.

Routing is decided in a fixed order. A breakpoint whose per-privilege debug enable is set is diverted into debug mode. Otherwise, if debug mode is already active, the PC is sent to the debug exception entry and nothing else changes. Otherwise the trap is delegated to supervisor or kept in machine mode. The delegation decision reads the interrupt mask when the cause MSB is set and the exception mask when it is clear.

The trap request is a plain strobe with no back-pressure. The block accepts a trap on every cycle in which `trap_valid` is high, including back-to-back cycles. Each accepted trap produces exactly one `upd_valid` pulse, which the consumer must take in that cycle.

Top module: `trap_entry_ctrl`

## Requirements
- R1: A trap sampled with `trap_valid` high on a rising edge produces a one-cycle `upd_valid` pulse in the following cycle, and all enables in the bundle are low in any cycle without `upd_valid`. Traps on consecutive cycles each produce their own bundle.
- R2: A cause equal to 3 with `brk_en[cur_priv]` set enters debug mode. The debug write carries cause code 1, the current privilege and the faulting PC. The next privilege is machine (3) and the next PC is 0x800. There is no status, cause or reservation write.
- R3: When `dbg_cause_in` is nonzero and R2 does not apply, the next PC is 0x808, the next privilege equals the current one, and every write enable, the reservation clear and the flush stay low.
- R4: When the cause MSB is set, the delegation bit is taken from `irq_deleg`, indexed by the cause with the MSB removed. When the MSB is clear, the bit is taken from `exc_deleg`.
- R5: A non-debug trap goes to supervisor only when all three hold: the current privilege is at most supervisor (U=0, S=1), the index is below XLEN, and the selected delegation bit is set. In every other case it goes to machine.
- R6: Supervisor entry sets the next PC to `svec` and the next privilege to 1. It asserts `s_we` with the cause and faulting PC on the cause and EPC outputs. It asserts `bad_we` only when `trap_has_addr` is high.
- R7: On supervisor entry the new status word copies `status_in`, with three changes. Bit 5 takes `status_in[cur_priv]`. Bit 8 takes the current privilege. Bit 1 is cleared.
- R8: Machine entry sets the next PC to `mvec` and the next privilege to 3, and asserts `m_we`, with `bad_we` following `trap_has_addr`. The status word copies `status_in` with three changes. Bit 7 takes `status_in[cur_priv]`. Bits 12:11 take the current privilege. Bit 3 is cleared.
- R9: `resv_clear` pulses with every supervisor or machine entry and never with a debug route.
- R10: `tlb_flush` pulses with the bundle exactly when the next privilege differs from the current one.
- R11: The breakpoint check of R2 takes precedence over an already active debug state. A breakpoint whose enable for the current privilege is clear is routed as an ordinary exception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Trap request strobe |
| trap_cause | input | XLEN | Cause; MSB marks an interrupt |
| trap_pc | input | XLEN | Faulting PC |
| trap_has_addr | input | 1 | Trap carries a bad address |
| trap_addr | input | XLEN | Bad address value |
| cur_priv | input | 2 | Current privilege (U=0, S=1, H=2, M=3) |
| status_in | input | XLEN | Current status word |
| exc_deleg | input | XLEN | Exception delegation mask |
| irq_deleg | input | XLEN | Interrupt delegation mask |
| svec | input | XLEN | Supervisor trap vector |
| mvec | input | XLEN | Machine trap vector |
| brk_en | input | 4 | Breakpoint-to-debug enable per privilege |
| dbg_cause_in | input | 3 | Current debug cause; nonzero means debug mode |
| upd_valid | output | 1 | Update bundle valid |
| next_pc | output | XLEN | New PC |
| next_priv | output | 2 | New privilege |
| s_we | output | 1 | Write supervisor cause and EPC |
| m_we | output | 1 | Write machine cause and EPC |
| bad_we | output | 1 | Write bad address of the selected mode |
| cause_o | output | XLEN | Cause data |
| epc_o | output | XLEN | Exception-PC data |
| bad_o | output | XLEN | Bad-address data |
| status_we | output | 1 | Write status word |
| status_o | output | XLEN | New status word |
| dbg_we | output | 1 | Write debug state |
| dbg_cause_o | output | 3 | New debug cause |
| dbg_priv_o | output | 2 | Saved privilege for debug |
| dbg_pc_o | output | XLEN | Debug PC |
| resv_clear | output | 1 | Invalidate load reservation |
| tlb_flush | output | 1 | Translation flush pulse |

## Verification
Exceptions and interrupts are driven with both delegation masks set opposite to each other. This shows that the cause MSB picks the mask, and a cause index of 40 shows the range guard. The same delegated cause is raised from user and from machine privilege, which separates the privilege limit from the mask bit. It also gives one case where the privilege changes and one where it does not, which exercises the flush. Breakpoints are sent with the enable set and clear, and with debug mode active and inactive, to fix the order between diversion and the debug exception entry. Traps with and without an address, and two traps on back-to-back cycles, complete the patterns.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    PRV_U = 2'd0,
    PRV_S = 2'd1,
    PRV_H = 2'd2,
    PRV_M = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    RT_DBG_BRK = 2'd0,
    RT_DBG_EXC = 2'd1,
    RT_SUP     = 2'd2,
    RT_MACH    = 2'd3
  } route_e;

  // Status bit positions; the per-privilege enable sits at bit index = privilege
  localparam int ST_SIE  = 1;
  localparam int ST_MIE  = 3;
  localparam int ST_SPIE = 5;
  localparam int ST_MPIE = 7;
  localparam int ST_SPP  = 8;
  localparam int ST_MPP  = 11;
endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int BRK_CAUSE = 3
) (
  input  logic [XLEN-1:0] cause,
  input  logic [1:0]      priv,
  input  logic [XLEN-1:0] exc_deleg,
  input  logic [XLEN-1:0] irq_deleg,
  input  logic [3:0]      brk_en,
  input  logic            dbg_active,
  output route_e          route
);
  localparam int IDXW = $clog2(XLEN);
  localparam logic [XLEN-1:0] BRK_V  = XLEN'(BRK_CAUSE);
  localparam logic [XLEN-1:0] XLEN_V = XLEN'(XLEN);

  logic            is_irq;
  logic [XLEN-1:0] idx;
  logic [XLEN-1:0] sel_mask;
  logic            in_range;
  logic            deleg_bit;
  logic            brk_hit;

  always_comb begin
    is_irq    = cause[XLEN-1];
    idx       = {1'b0, cause[XLEN-2:0]};
    sel_mask  = is_irq ? irq_deleg : exc_deleg;
    in_range  = idx < XLEN_V;
    deleg_bit = in_range && sel_mask[idx[IDXW-1:0]];
    brk_hit   = (cause == BRK_V) && brk_en[priv];
    if (brk_hit)
      route = RT_DBG_BRK;
    else if (dbg_active)
      route = RT_DBG_EXC;
    else if ((priv <= PRV_S) && deleg_bit)
      route = RT_SUP;
    else
      route = RT_MACH;
  end
endmodule

// File: rtl/trap_stack.sv
module trap_stack
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] status_in,
  input  logic [1:0]      priv,
  input  logic            to_sup,
  output logic [XLEN-1:0] status_out
);
  logic cur_ie;

  always_comb begin
    cur_ie     = status_in[priv];
    status_out = status_in;
    if (to_sup) begin
      status_out[ST_SPIE] = cur_ie;
      status_out[ST_SPP]  = priv[0];
      status_out[ST_SIE]  = 1'b0;
    end else begin
      status_out[ST_MPIE]            = cur_ie;
      status_out[ST_MPP+1:ST_MPP]    = priv;
      status_out[ST_MIE]             = 1'b0;
    end
  end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter int              BRK_CAUSE   = 3,
  parameter logic [2:0]      SWBP_CODE   = 3'd1,
  parameter logic [XLEN-1:0] DBG_ROM     = 'h800,
  parameter logic [XLEN-1:0] DBG_ROM_EXC = 'h808
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_valid,
  input  logic [XLEN-1:0] trap_cause,
  input  logic [XLEN-1:0] trap_pc,
  input  logic            trap_has_addr,
  input  logic [XLEN-1:0] trap_addr,
  input  logic [1:0]      cur_priv,
  input  logic [XLEN-1:0] status_in,
  input  logic [XLEN-1:0] exc_deleg,
  input  logic [XLEN-1:0] irq_deleg,
  input  logic [XLEN-1:0] svec,
  input  logic [XLEN-1:0] mvec,
  input  logic [3:0]      brk_en,
  input  logic [2:0]      dbg_cause_in,
  output logic            upd_valid,
  output logic [XLEN-1:0] next_pc,
  output logic [1:0]      next_priv,
  output logic            s_we,
  output logic            m_we,
  output logic            bad_we,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] bad_o,
  output logic            status_we,
  output logic [XLEN-1:0] status_o,
  output logic            dbg_we,
  output logic [2:0]      dbg_cause_o,
  output logic [1:0]      dbg_priv_o,
  output logic [XLEN-1:0] dbg_pc_o,
  output logic            resv_clear,
  output logic            tlb_flush
);
  route_e          route;
  logic [XLEN-1:0] stacked;
  logic [XLEN-1:0] pc_d;
  logic [1:0]      priv_d;
  logic            arch_trap;

  trap_route #(.XLEN(XLEN), .BRK_CAUSE(BRK_CAUSE)) u_route (
    .cause      (trap_cause),
    .priv       (cur_priv),
    .exc_deleg  (exc_deleg),
    .irq_deleg  (irq_deleg),
    .brk_en     (brk_en),
    .dbg_active (dbg_cause_in != 3'd0),
    .route      (route)
  );

  trap_stack #(.XLEN(XLEN)) u_stack (
    .status_in  (status_in),
    .priv       (cur_priv),
    .to_sup     (route == RT_SUP),
    .status_out (stacked)
  );

  always_comb begin
    arch_trap = (route == RT_SUP) || (route == RT_MACH);
    unique case (route)
      RT_DBG_BRK: begin pc_d = DBG_ROM;     priv_d = PRV_M;    end
      RT_DBG_EXC: begin pc_d = DBG_ROM_EXC; priv_d = cur_priv; end
      RT_SUP:     begin pc_d = svec;        priv_d = PRV_S;    end
      default:    begin pc_d = mvec;        priv_d = PRV_M;    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_valid   <= 1'b0;
      next_pc     <= '0;
      next_priv   <= PRV_M;
      s_we        <= 1'b0;
      m_we        <= 1'b0;
      bad_we      <= 1'b0;
      cause_o     <= '0;
      epc_o       <= '0;
      bad_o       <= '0;
      status_we   <= 1'b0;
      status_o    <= '0;
      dbg_we      <= 1'b0;
      dbg_cause_o <= '0;
      dbg_priv_o  <= '0;
      dbg_pc_o    <= '0;
      resv_clear  <= 1'b0;
      tlb_flush   <= 1'b0;
    end else begin
      upd_valid  <= trap_valid;
      s_we       <= trap_valid && (route == RT_SUP);
      m_we       <= trap_valid && (route == RT_MACH);
      bad_we     <= trap_valid && arch_trap && trap_has_addr;
      status_we  <= trap_valid && arch_trap;
      resv_clear <= trap_valid && arch_trap;
      dbg_we     <= trap_valid && (route == RT_DBG_BRK);
      tlb_flush  <= trap_valid && (priv_d != cur_priv);
      if (trap_valid) begin
        next_pc   <= pc_d;
        next_priv <= priv_d;
        if (arch_trap) begin
          cause_o  <= trap_cause;
          epc_o    <= trap_pc;
          status_o <= stacked;
          if (trap_has_addr) bad_o <= trap_addr;
        end
        if (route == RT_DBG_BRK) begin
          dbg_cause_o <= SWBP_CODE;
          dbg_priv_o  <= cur_priv;
          dbg_pc_o    <= trap_pc;
        end
      end
    end
  end
endmodule

// File: rtl/trap_entry_ctrl_chk.sv
module trap_entry_ctrl_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_valid,
  input logic [XLEN-1:0] trap_pc,
  input logic            trap_has_addr,
  input logic [1:0]      cur_priv,
  input logic [XLEN-1:0] svec,
  input logic [XLEN-1:0] mvec,
  input logic            upd_valid,
  input logic [XLEN-1:0] next_pc,
  input logic [1:0]      next_priv,
  input logic            s_we,
  input logic            m_we,
  input logic            bad_we,
  input logic            status_we,
  input logic [XLEN-1:0] status_o,
  input logic            dbg_we,
  input logic [XLEN-1:0] dbg_pc_o,
  input logic            resv_clear,
  input logic            tlb_flush
);
  AST_BUNDLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> upd_valid); // R1
  AST_NO_STRAY_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |-> !(s_we || m_we || bad_we || status_we || dbg_we || resv_clear || tlb_flush)); // R1
  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({s_we, m_we, dbg_we})); // R5
  AST_DEBUG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_we |-> (next_priv == 2'd3) && (dbg_pc_o == $past(trap_pc)) && !status_we); // R2
  AST_SUP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    s_we |-> (next_pc == $past(svec)) && (next_priv == 2'd1) && !status_o[1]); // R6
  AST_SUP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    s_we |-> ($past(cur_priv) <= 2'd1)); // R5
  AST_MACH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    m_we |-> (next_pc == $past(mvec)) && (next_priv == 2'd3) && !status_o[3]); // R8
  AST_BAD_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    bad_we |-> $past(trap_has_addr) && (s_we || m_we)); // R6
  AST_RESV_ARCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (resv_clear == (s_we || m_we))); // R9
  AST_FLUSH_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (tlb_flush == (next_priv != $past(cur_priv)))); // R10
endmodule

bind trap_entry_ctrl trap_entry_ctrl_chk #(.XLEN(XLEN)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .trap_valid    (trap_valid),
  .trap_pc       (trap_pc),
  .trap_has_addr (trap_has_addr),
  .cur_priv      (cur_priv),
  .svec          (svec),
  .mvec          (mvec),
  .upd_valid     (upd_valid),
  .next_pc       (next_pc),
  .next_priv     (next_priv),
  .s_we          (s_we),
  .m_we          (m_we),
  .bad_we        (bad_we),
  .status_we     (status_we),
  .status_o      (status_o),
  .dbg_we        (dbg_we),
  .dbg_pc_o      (dbg_pc_o),
  .resv_clear    (resv_clear),
  .tlb_flush     (tlb_flush)
);

// File: tb/sim_trap_entry_ctrl.sv
module sim_trap_entry_ctrl;
  localparam int XLEN = 32;
  localparam int PW   = 206;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            trap_valid = 1'b0;
  logic [XLEN-1:0] trap_cause = '0;
  logic [XLEN-1:0] trap_pc = '0;
  logic            trap_has_addr = 1'b0;
  logic [XLEN-1:0] trap_addr = '0;
  logic [1:0]      cur_priv = 2'd0;
  logic [XLEN-1:0] status_in = '0;
  logic [XLEN-1:0] exc_deleg = '0;
  logic [XLEN-1:0] irq_deleg = '0;
  logic [XLEN-1:0] svec = 32'h0000_1000;
  logic [XLEN-1:0] mvec = 32'h0000_2000;
  logic [3:0]      brk_en = 4'd0;
  logic [2:0]      dbg_cause_in = 3'd0;

  logic            upd_valid, s_we, m_we, bad_we, status_we, dbg_we, resv_clear, tlb_flush;
  logic [XLEN-1:0] next_pc, cause_o, epc_o, bad_o, status_o, dbg_pc_o;
  logic [1:0]      next_priv, dbg_priv_o;
  logic [2:0]      dbg_cause_o;

  int errors = 0;
  int checks = 0;
  logic [PW-1:0] exp_q[$];
  int            tag_q[$];

  always #10 clk = ~clk;

  trap_entry_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_cause(trap_cause),
    .trap_pc(trap_pc), .trap_has_addr(trap_has_addr), .trap_addr(trap_addr),
    .cur_priv(cur_priv), .status_in(status_in), .exc_deleg(exc_deleg),
    .irq_deleg(irq_deleg), .svec(svec), .mvec(mvec), .brk_en(brk_en),
    .dbg_cause_in(dbg_cause_in), .upd_valid(upd_valid), .next_pc(next_pc),
    .next_priv(next_priv), .s_we(s_we), .m_we(m_we), .bad_we(bad_we),
    .cause_o(cause_o), .epc_o(epc_o), .bad_o(bad_o), .status_we(status_we),
    .status_o(status_o), .dbg_we(dbg_we), .dbg_cause_o(dbg_cause_o),
    .dbg_priv_o(dbg_priv_o), .dbg_pc_o(dbg_pc_o), .resv_clear(resv_clear),
    .tlb_flush(tlb_flush)
  );

  function automatic logic [PW-1:0] pack(
    input logic [XLEN-1:0] pc, input logic [1:0] pv,
    input logic sw, input logic mw, input logic bw, input logic stw,
    input logic dw, input logic rc, input logic fl,
    input logic [XLEN-1:0] c, input logic [XLEN-1:0] e, input logic [XLEN-1:0] b,
    input logic [XLEN-1:0] st, input logic [2:0] dc, input logic [1:0] dp,
    input logic [XLEN-1:0] dpc);
    // Data fields are masked to zero when their enable is low
    return {pc, pv, sw, mw, bw, stw, dw, rc, fl,
            (sw || mw) ? c : '0, (sw || mw) ? e : '0, bw ? b : '0,
            stw ? st : '0, dw ? dc : 3'd0, dw ? dp : 2'd0, dw ? dpc : '0};
  endfunction

  // Expected bundle computed from the requirements
  function automatic logic [PW-1:0] model();
    logic brk, sup, dbgx, irq, dbit, flush;
    logic [XLEN-1:0] idx, st;
    logic [1:0] np;
    brk  = (trap_cause == 32'd3) && brk_en[cur_priv];          // R2, R11
    dbgx = !brk && (dbg_cause_in != 3'd0);                     // R3
    irq  = trap_cause[XLEN-1];
    idx  = {1'b0, trap_cause[XLEN-2:0]};
    dbit = (idx < 32) && (irq ? irq_deleg[idx[4:0]] : exc_deleg[idx[4:0]]); // R4
    sup  = !brk && !dbgx && (cur_priv <= 2'd1) && dbit;        // R5
    if (brk) begin
      np = 2'd3;
      return pack(32'h800, np, 0, 0, 0, 0, 1, 0, np != cur_priv,
                  '0, '0, '0, '0, 3'd1, cur_priv, trap_pc);
    end
    if (dbgx)
      return pack(32'h808, cur_priv, 0, 0, 0, 0, 0, 0, 0, '0, '0, '0, '0, 3'd0, 2'd0, '0);
    st = status_in;
    if (sup) begin                                             // R6, R7
      st[5] = status_in[cur_priv]; st[8] = cur_priv[0]; st[1] = 1'b0;
      np = 2'd1;
      flush = (np != cur_priv);
      return pack(svec, np, 1, 0, trap_has_addr, 1, 0, 1, flush,
                  trap_cause, trap_pc, trap_addr, st, 3'd0, 2'd0, '0);
    end
    st[7] = status_in[cur_priv]; st[12:11] = cur_priv; st[3] = 1'b0; // R8
    np = 2'd3;
    flush = (np != cur_priv);
    return pack(mvec, np, 0, 1, trap_has_addr, 1, 0, 1, flush,
                trap_cause, trap_pc, trap_addr, st, 3'd0, 2'd0, '0);
  endfunction

  task automatic send(input int tag);
    exp_q.push_back(model());
    tag_q.push_back(tag);
    trap_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle();
    trap_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops one expected bundle per upd_valid
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && upd_valid) begin
        logic [PW-1:0] act, ex;
        int tg;
        act = pack(next_pc, next_priv, s_we, m_we, bad_we, status_we, dbg_we,
                   resv_clear, tlb_flush, cause_o, epc_o, bad_o, status_o,
                   dbg_cause_o, dbg_priv_o, dbg_pc_o);
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R1: unexpected bundle act=%h exp=none", act);
        end else begin
          ex = exp_q.pop_front();
          tg = tag_q.pop_front();
          if (act !== ex) begin
            errors++;
            $display("FAIL R%0d: act=%h exp=%h", tg, act, ex);
          end
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (upd_valid !== 1'b0 || resv_clear !== 1'b0 || tlb_flush !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset act=%b%b%b exp=000", upd_valid, resv_clear, tlb_flush);
    end

    exc_deleg = 32'h0000_0004; irq_deleg = 32'h0000_0020;
    // R5 R6 R7 R10: delegated exception from user, with address
    cur_priv = 2'd0; status_in = 32'h0000_0001; trap_cause = 32'd2;
    trap_pc = 32'h100; trap_has_addr = 1'b1; trap_addr = 32'hDEAD_0000;
    send(5); idle();
    // R5 R10: same cause from machine stays in machine, no flush
    cur_priv = 2'd3; status_in = 32'h0000_0008;
    send(5); idle();
    // R4 R6: interrupt 5 uses irq mask, no address so bad_we low
    cur_priv = 2'd1; status_in = 32'h0000_0002; trap_cause = 32'h8000_0005;
    trap_has_addr = 1'b0;
    send(4); idle();
    // R4: interrupt 5 with irq bit clear and exc bit set goes to machine
    irq_deleg = 32'h0; exc_deleg = 32'h0000_0020;
    send(4); idle();
    // R5: index 40 is out of range even with full mask
    exc_deleg = 32'hFFFF_FFFF; cur_priv = 2'd0; trap_cause = 32'd40;
    send(5); idle();
    // R8: machine entry from supervisor with address, stacking
    exc_deleg = 32'h0; cur_priv = 2'd1; status_in = 32'h0000_0022;
    trap_cause = 32'd7; trap_has_addr = 1'b1; trap_addr = 32'h0000_BEEF;
    send(8); idle();
    // R2: breakpoint from supervisor with enable set
    trap_cause = 32'd3; brk_en = 4'b0010; trap_pc = 32'h240; trap_has_addr = 1'b0;
    send(2); idle();
    // R11: breakpoint with enable clear for current privilege is ordinary
    brk_en = 4'b1000;
    send(11); idle();
    // R3: debug already active, ordinary exception
    dbg_cause_in = 3'd3; trap_cause = 32'd2; trap_pc = 32'h300;
    send(3); idle();
    // R11: enabled breakpoint wins over active debug
    cur_priv = 2'd3; trap_cause = 32'd3;
    send(11); idle();
    // R9: reservation and back-to-back traps (R1)
    dbg_cause_in = 3'd0; brk_en = 4'd0; exc_deleg = 32'h0000_0100;
    cur_priv = 2'd0; trap_cause = 32'd8; trap_pc = 32'h400;
    send(9);
    cur_priv = 2'd1; trap_cause = 32'd9; trap_pc = 32'h404;
    send(1);
    idle();

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1: missing bundles act=%0d exp=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL R1: watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule